// File: doc/BRIEF.md
# Deferred-Reduction Field Adder/Subtracter

This block adds or subtracts two wide field elements for elliptic-curve arithmetic over an arbitrary prime modulus M, and never reduces the outcome modulo M. A sum is returned exactly as A + B. A difference is returned as A − B + 4M, so it can never go negative. Every result therefore stays below 8M, and the caller passes it straight to a Montgomery multiplier whose enlarged R tolerates that range. The reduction happens inside that multiplication.

Operands up to 4M − 1 wide are taken in on a start pulse. The adder walks through them in fixed-width slices, one slice per clock, and keeps a small carry register between slices. The subtract path supplies the inverted subtrahend, the shifted modulus and the +1 of the two's complement to one three-input carry chain. The result register is three bits wider than the modulus. For 256-bit moduli the whole operation takes seven cycles, counting the cycle in which start is sampled, and a one-cycle done pulse ends it.

Top module: `lazy_addsub`

## Requirements
- R1: With opSub = 0, result equals opA + opB exactly, with no correction by the modulus.
- R2: With opSub = 1, result equals opA − opB + 4·modulus. The 4·modulus term is the modulus shifted left by two bit positions.
- R3: result is OP_W + 3 bits wide. When both operands are below 4·modulus, every result is below 8·modulus, and every subtraction result is greater than zero.
- R4: done is high for exactly one cycle, in the seventh cycle when the start cycle is counted as the first. With NSLICE = ceil((OP_W+3)/SLICE_W), done follows the accepted start edge by NSLICE + 1 rising edges.
- R5: opSub, opA, opB and modulus are sampled only on the edge that accepts start. Later changes to them do not affect the result of the running operation.
- R6: The block ignores start while an operation is in progress, including the cycle before done. Such a start neither restarts the operation nor moves the done pulse. If start is held high, the block accepts a new operation on the edge that ends the done cycle.
- R7: result holds its value from one done pulse until the next, and changes only on the edge that raises done.
- R8: Synchronous active-high reset clears done and result to zero and aborts any operation in progress.
- R9: A subtraction with opA < opB returns a positive value congruent to opA − opB modulo the modulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request an operation; accepted only when idle |
| opSub | input | 1 | 0 = add, 1 = subtract with 4·modulus offset |
| opA | input | OP_W+2 | First operand, below 4·modulus |
| opB | input | OP_W+2 | Second operand, below 4·modulus |
| modulus | input | OP_W | Field prime M |
| done | output | 1 | One-cycle completion pulse |
| result | output | OP_W+3 | Unreduced sum or offset difference |

## Verification
The embedded assertions check on every cycle that the slice carry never exceeds two, that no bit above the result width is ever set when the result is committed, that done never lasts longer than a cycle, that a running operation never sees a second load, and that result changes only on a commit. Only the bench scenarios can show the arithmetic values, the seven-cycle latency and the congruence of borrowing subtractions. The same holds for the property that operands changed in mid-flight or extra start pulses leave the running operation alone. A behavioural model in the bench predicts done and result for every cycle, and the bench compares them against the design at each clock, across several moduli and both extremes of the operand range.

// File: rtl/lazy_addsub_pkg.sv
package lazy_addsub_pkg;

  typedef struct packed {
    logic load;    // capture operands, start a new pass
    logic step;    // process one slice
    logic commit;  // copy accumulated value to the output
  } ctrl_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } ctrl_state_t;

endpackage

// File: rtl/lazy_addsub_slice.sv
module lazy_addsub_slice #(
  parameter int SLICE_W = 54
) (
  input  logic [SLICE_W-1:0] sliceA,
  input  logic [SLICE_W-1:0] sliceB,
  input  logic [SLICE_W-1:0] sliceM,
  input  logic [1:0]         carryIn,
  output logic [SLICE_W-1:0] sliceSum,
  output logic [1:0]         carryOut
);

  localparam int SUM_W = SLICE_W + 2;

  logic [SUM_W-1:0] total;

  always_comb begin
    total = {2'b00, sliceA} + {2'b00, sliceB} + {2'b00, sliceM}
          + {{SLICE_W{1'b0}}, carryIn};
    sliceSum = total[SLICE_W-1:0];
    carryOut = total[SUM_W-1:SLICE_W];
  end

endmodule

// File: rtl/lazy_addsub_ctrl.sv
module lazy_addsub_ctrl
  import lazy_addsub_pkg::*;
#(
  parameter int NSLICE = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  output ctrl_strobe_t strb,
  output logic         done
);

  localparam int CNT_W = $clog2(NSLICE + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NSLICE - 1);

  ctrl_state_t     stateQ;
  logic [CNT_W-1:0] cntQ;
  logic            doneQ;

  always_comb begin
    strb.load   = (stateQ == ST_IDLE) && start;
    strb.step   = (stateQ == ST_RUN);
    strb.commit = (stateQ == ST_FIN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= strb.commit;
      case (stateQ)
        ST_IDLE: begin
          if (start) begin
            stateQ <= ST_RUN;
            cntQ   <= '0;
          end
        end
        ST_RUN: begin
          if (cntQ == LAST_CNT) stateQ <= ST_FIN;
          cntQ <= cntQ + 1'b1;
        end
        ST_FIN:  stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign done = doneQ;

  // R4: completion pulse never lasts two cycles
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4: slice counter stays inside the pass while running
  assert_slice_count_R4: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_RUN) |-> (cntQ <= LAST_CNT));

endmodule

// File: rtl/lazy_addsub_dp.sv
module lazy_addsub_dp
  import lazy_addsub_pkg::*;
#(
  parameter int OP_W    = 256,
  parameter int SLICE_W = 54,
  parameter int RES_W   = OP_W + 3,
  parameter int NSLICE  = (RES_W + SLICE_W - 1) / SLICE_W,
  parameter int PAD_W   = NSLICE * SLICE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_strobe_t     strb,
  input  logic             opSub,
  input  logic [OP_W+1:0]  opA,
  input  logic [OP_W+1:0]  opB,
  input  logic [OP_W-1:0]  modulus,
  output logic [RES_W-1:0] result
);

  logic [PAD_W-1:0]   aQ, bQ, mQ, accQ;
  logic [1:0]         carryQ;
  logic [RES_W-1:0]   resQ;
  logic [SLICE_W-1:0] sliceSum;
  logic [1:0]         carryNext;
  logic [PAD_W-1:0]   accNext;

  lazy_addsub_slice #(.SLICE_W(SLICE_W)) slice_i (
    .sliceA  (aQ[SLICE_W-1:0]),
    .sliceB  (bQ[SLICE_W-1:0]),
    .sliceM  (mQ[SLICE_W-1:0]),
    .carryIn (carryQ),
    .sliceSum(sliceSum),
    .carryOut(carryNext)
  );

  generate
    if (NSLICE > 1) begin : g_multi
      assign accNext = {sliceSum, accQ[PAD_W-1:SLICE_W]};
    end else begin : g_single
      assign accNext = sliceSum;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      aQ     <= '0;
      bQ     <= '0;
      mQ     <= '0;
      accQ   <= '0;
      carryQ <= '0;
      resQ   <= '0;
    end else begin
      if (strb.load) begin
        aQ     <= PAD_W'(opA);
        bQ     <= opSub ? ~(PAD_W'(opB)) : PAD_W'(opB);
        mQ     <= opSub ? PAD_W'({modulus, 2'b00}) : '0;
        carryQ <= {1'b0, opSub};
        accQ   <= '0;
      end else if (strb.step) begin
        aQ     <= aQ >> SLICE_W;
        bQ     <= bQ >> SLICE_W;
        mQ     <= mQ >> SLICE_W;
        accQ   <= accNext;
        carryQ <= carryNext;
      end
      if (strb.commit) resQ <= accQ[RES_W-1:0];
    end
  end

  assign result = resQ;

  // R1: three slice inputs plus a carry of at most two never carry out more than two
  assert_carry_bound_R1: assert property (@(posedge clk) disable iff (rst)
    strb.step |-> (carryQ <= 2'd2));

  // R6: a pass in progress never sees a fresh load
  assert_no_reload_R6: assert property (@(posedge clk) disable iff (rst)
    strb.step |-> !strb.load);

  // R7: output moves only on commit
  assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !strb.commit |=> $stable(result));

  generate
    if (PAD_W > RES_W) begin : g_pad_chk
      // R3: nothing spills past the result width
      assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        strb.commit |-> (accQ[PAD_W-1:RES_W] == '0));
    end
  endgenerate

endmodule

// File: rtl/lazy_addsub.sv
module lazy_addsub
  import lazy_addsub_pkg::*;
#(
  parameter int OP_W    = 256,
  parameter int SLICE_W = 54
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            opSub,
  input  logic [OP_W+1:0] opA,
  input  logic [OP_W+1:0] opB,
  input  logic [OP_W-1:0] modulus,
  output logic            done,
  output logic [OP_W+2:0] result
);

  localparam int RES_W  = OP_W + 3;
  localparam int NSLICE = (RES_W + SLICE_W - 1) / SLICE_W;
  localparam int PAD_W  = NSLICE * SLICE_W;

  ctrl_strobe_t strb;

  lazy_addsub_ctrl #(.NSLICE(NSLICE)) ctrl_i (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .strb (strb),
    .done (done)
  );

  lazy_addsub_dp #(
    .OP_W   (OP_W),
    .SLICE_W(SLICE_W),
    .RES_W  (RES_W),
    .NSLICE (NSLICE),
    .PAD_W  (PAD_W)
  ) dp_i (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .opSub  (opSub),
    .opA    (opA),
    .opB    (opB),
    .modulus(modulus),
    .result (result)
  );

endmodule

// File: tb/lazy_addsub_tb_top.sv
`timescale 1ns/1ps
module lazy_addsub_tb_top;

  localparam int OP_W  = 256;
  localparam int RES_W = OP_W + 3;
  localparam int LAT   = 7;   // start cycle counts as first

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic            opSub = 1'b0;
  logic [OP_W+1:0] opA = '0;
  logic [OP_W+1:0] opB = '0;
  logic [OP_W-1:0] modulus = '0;
  logic            done;
  logic [RES_W-1:0] result;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  lazy_addsub #(.OP_W(OP_W), .SLICE_W(54)) dut_i (
    .clk(clk), .rst(rst), .start(start), .opSub(opSub),
    .opA(opA), .opB(opB), .modulus(modulus),
    .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [RES_W+1:0] act, input logic [RES_W+1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int              remain = 0;
  logic            expDone = 1'b0;
  logic [RES_W-1:0] pending = '0, held = '0;
  logic            capSub = 1'b0, heldSub = 1'b0;
  logic [RES_W+1:0] capA = '0, capB = '0, capM = '0;
  logic [RES_W+1:0] hA = '0, hB = '0, hM = '0;

  always @(posedge clk) begin
    if (rst) begin
      remain  = 0;
      expDone = 1'b0;
      held    = '0;
    end else begin
      expDone = 1'b0;
      if (remain > 0) begin
        remain--;
        if (remain == 0) begin
          expDone = 1'b1;
          held    = pending;
          heldSub = capSub;
          hA = capA; hB = capB; hM = capM;
        end
      end else if (start) begin
        remain = LAT - 1;
        capSub = opSub;
        capA   = (RES_W+2)'(opA);
        capB   = (RES_W+2)'(opB);
        capM   = (RES_W+2)'(modulus);
        if (opSub) pending = RES_W'(capA + 4 * capM - capB);
        else       pending = RES_W'(capA + capB);
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(done === expDone, "R4 done timing", done, expDone);
      if (expDone) begin
        chk(result === held, heldSub ? "R2 difference" : "R1 sum", result, held);
        chk((RES_W+2)'(result) < 8 * hM, "R3 below 8M", result, 8 * hM);
        if (heldSub) begin
          chk(result != '0, "R3 positive difference", result, 1);
          if (hA < hB)
            chk(((RES_W+2)'(result) + hB - hA) % hM == '0,
                "R9 congruent borrow", result, held);
        end
      end else begin
        chk(result === held, "R7 result hold", result, held);
      end
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [OP_W+1:0] rnd(input logic [OP_W-1:0] m);
    logic [287:0] r;
    logic [287:0] lim;
    r = {$urandom, $urandom, $urandom, $urandom, $urandom,
         $urandom, $urandom, $urandom, $urandom};
    lim = 288'(m) << 2;
    return (OP_W+2)'(r % lim);
  endfunction

  // busyPoke: extra start pulses during the pass (R6)
  task automatic runOp(input bit sub, input logic [OP_W+1:0] a,
                       input logic [OP_W+1:0] b, input logic [OP_W-1:0] m,
                       input bit busyPoke);
    @(negedge clk);
    opSub = sub; opA = a; opB = b; modulus = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R5: scramble captured inputs mid-flight
    opSub = ~sub; opA = rnd(m); opB = rnd(m); modulus = ~m;
    for (int i = 0; i < LAT; i++) begin
      if (busyPoke && (i == 1 || i == LAT - 3)) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic finishRun;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    logic [OP_W-1:0] mBig, mMid, mSmall;
    mBig   = {OP_W{1'b1}} - 256'd188;
    mMid   = (256'd1 << 255) - 256'd19;
    mSmall = 256'd97;

    repeat (3) @(negedge clk);
    // R8: reset state
    chk(done === 1'b0, "R8 reset done", done, 0);
    chk(result === '0, "R8 reset result", result, 0);
    rst = 1'b0;

    // R1 / R3: sum extremes
    runOp(1'b0, (OP_W+2)'(4 * (RES_W+2)'(mBig) - 1),
                (OP_W+2)'(4 * (RES_W+2)'(mBig) - 1), mBig, 1'b0);
    runOp(1'b0, 1, 2, mSmall, 1'b0);
    // R2 / R9: difference extremes
    runOp(1'b1, 0, (OP_W+2)'(4 * (RES_W+2)'(mBig) - 1), mBig, 1'b0);
    runOp(1'b1, (OP_W+2)'(4 * (RES_W+2)'(mBig) - 1), 0, mBig, 1'b0);
    runOp(1'b1, 5, 90, mSmall, 1'b0);
    // R6: start pokes while busy
    runOp(1'b1, rnd(mMid), rnd(mMid), mMid, 1'b1);
    runOp(1'b0, rnd(mMid), rnd(mMid), mMid, 1'b1);
    // random mix
    for (int k = 0; k < 40; k++) begin
      logic [OP_W-1:0] m;
      m = (k % 3 == 0) ? mBig : ((k % 3 == 1) ? mMid : mSmall);
      runOp(k[0], rnd(m), rnd(m), m, k[2]);
    end
    // R6: start held high, back-to-back acceptance
    @(negedge clk);
    opSub = 1'b1; opA = 3; opB = 200; modulus = mSmall; start = 1'b1;
    repeat (3 * LAT) @(negedge clk);
    start = 1'b0;
    repeat (LAT + 2) @(negedge clk);
    // R8: reset mid-pass aborts
    @(negedge clk);
    opSub = 1'b0; opA = 7; opB = 8; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(done === 1'b0, "R8 abort done", done, 0);
    chk(result === '0, "R8 abort result", result, 0);
    rst = 1'b0;
    repeat (LAT + 2) @(negedge clk);
    chk(done === 1'b0, "R8 no late done", done, 0);
    finishRun();
  end

endmodule